// File: doc/BRIEF.md
# Flag Offset Programming Loader

This block holds the four threshold offsets of a dual-direction FIFO pair. Each direction has an almost-empty offset and an almost-full offset. Downstream flag comparators read the four values continuously. The block also raises a single flag once programming is finished.

The programming method is chosen while the active-low master reset is held. It is sampled from a mode-select input and two select pins on the last clock edge at which reset is still low. Three methods are available:

- **Preset.** All four offsets take a fixed value (8, 16 or 64) and programming is complete at once.
- **Parallel.** A strobe writes a data word into each register in turn.
- **Serial.** After reset, the two select pins change role. One becomes an active-low serial enable and the other serial data. Together they shift a single chain that runs through all four registers.

Top module: `flag_offset_loader`

## Requirements
- R1: On every clock edge at which `mrst_n` is low, `prog_done` goes low and all four offsets are loaded. In preset mode they take the preset value; in every other mode they are cleared to zero.
- R2: The method is captured from the pins on the last edge with `mrst_n` low. If `ser_mode_n` = 0, the method is serial. If `ser_mode_n` = 1, the code {`cfg1_sen_n`,`cfg0_sdat`} selects it: 00 gives preset 64, 01 gives preset 16, 10 gives preset 8, and 11 gives parallel load.
- R3: In preset mode all four offsets equal the preset value. `prog_done` rises on the first edge after reset is released, and the pins and strobe have no further effect.
- R4: In serial mode, each edge with `mrst_n` high, `cfg1_sen_n` low and `prog_done` low shifts `cfg0_sdat` into a chain ordered {`ae_ofs_1`,`af_ofs_1`,`ae_ofs_2`,`af_ofs_2`}, most significant bit first. The first bit therefore ends in the MSB of `ae_ofs_1` and the last bit in the LSB of `af_ofs_2`.
- R5: In serial mode, an edge with `cfg1_sen_n` high takes no bit and leaves all offsets unchanged.
- R6: `prog_done` rises on the edge of exactly the 4×OFS_W-th serial bit, and not earlier. After that, further serial bits change nothing until the next master reset.
- R7: In parallel mode, each edge with `pload_strobe` high writes `pload_word` into the next register, in the order `ae_ofs_1`, `af_ofs_1`, `ae_ofs_2`, `af_ofs_2`. `prog_done` rises on the fourth write, and later strobes are ignored.
- R8: Inputs that belong to another method are ignored. The strobe has no effect in serial mode, and the serial enable has no effect in parallel mode.
- R9: Master reset takes priority over a serial bit or strobe presented on the same edge. After reset, programming restarts under the newly captured method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled on `clk` |
| ser_mode_n | input | 1 | Method select: low for serial, high for parallel or preset |
| cfg1_sen_n | input | 1 | Code bit 1 during reset; afterwards the serial enable, active low |
| cfg0_sdat | input | 1 | Code bit 0 during reset; afterwards the serial data |
| pload_word | input | OFS_W | Offset field of the wide parallel data port |
| pload_strobe | input | 1 | Parallel write strobe |
| ae_ofs_1 | output | OFS_W | Almost-empty offset, first direction |
| af_ofs_1 | output | OFS_W | Almost-full offset, first direction |
| ae_ofs_2 | output | OFS_W | Almost-empty offset, second direction |
| af_ofs_2 | output | OFS_W | Almost-full offset, second direction |
| prog_done | output | 1 | Programming complete |

## Verification
Two functions can land on the same edge: master reset and a serial shift. The bench drives `mrst_n` low on an edge while the serial enable is still low and a data bit is present, part way through a load. It then judges that the offsets are cleared and `prog_done` stays low rather than the bit being taken.

Completion and a further shift also meet. The bench sends one bit beyond the chain length and checks that the completed values do not move. In parallel mode it toggles the serial enable between strobes and checks that only the strobes count.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

  typedef enum logic [1:0] {
    MODE_SERIAL   = 2'd0,
    MODE_PARALLEL = 2'd1,
    MODE_PRESET   = 2'd2
  } load_mode_e;

  function automatic load_mode_e decode_mode(input logic ser_n, input logic [1:0] code);
    if (!ser_n)            return MODE_SERIAL;
    else if (code == 2'b11) return MODE_PARALLEL;
    else                    return MODE_PRESET;
  endfunction

  function automatic logic [7:0] preset_value(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd64;
      2'b01:   return 8'd16;
      2'b10:   return 8'd8;
      default: return 8'd0;
    endcase
  endfunction

  // number of load steps needed before programming is complete
  function automatic int unsigned steps_needed(input load_mode_e m, input int unsigned chain_len);
    case (m)
      MODE_SERIAL:   return chain_len;
      MODE_PARALLEL: return 4;
      default:       return 0;
    endcase
  endfunction

endpackage

// File: rtl/ofl_cfg_latch.sv
module ofl_cfg_latch
  import ofl_pkg::*;
(
  input  logic       clk,
  input  logic       mrst_n,
  input  load_mode_e dec_mode,
  input  logic [1:0] dec_code,
  output load_mode_e mode_q,
  output logic [1:0] code_q
);

  // follows the pins while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode_q <= dec_mode;
      code_q <= dec_code;
    end
  end

endmodule

// File: rtl/ofl_chain.sv
module ofl_chain #(
  parameter int OFS_W   = 10,
  parameter int CHAIN_L = 4 * OFS_W
) (
  input  logic               clk,
  input  logic               load_en,
  input  logic [OFS_W-1:0]   load_val,
  input  logic               ser_shift,
  input  logic               ser_bit,
  input  logic               par_shift,
  input  logic [OFS_W-1:0]   par_word,
  output logic [CHAIN_L-1:0] chain_q
);

  always_ff @(posedge clk) begin
    if (load_en)
      chain_q <= {4{load_val}};
    else if (ser_shift)
      chain_q <= {chain_q[CHAIN_L-2:0], ser_bit};
    else if (par_shift)
      chain_q <= {chain_q[CHAIN_L-OFS_W-1:0], par_word};
  end

endmodule

// File: rtl/ofl_progress.sv
module ofl_progress
  import ofl_pkg::*;
#(
  parameter int CHAIN_L = 40,
  parameter int CNT_W   = $clog2(CHAIN_L + 1)
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  load_mode_e       mode_q,
  input  logic             step,
  output logic [CNT_W-1:0] step_cnt,
  output logic             done_q
);

  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_next;

  assign target   = CNT_W'(steps_needed(mode_q, CHAIN_L));
  assign cnt_next = step_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      step_cnt <= '0;
      done_q   <= 1'b0;
    end else if (mode_q == MODE_PRESET) begin
      done_q <= 1'b1;
    end else if (step) begin
      step_cnt <= cnt_next;
      if (cnt_next == target) done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import ofl_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             ser_mode_n,
  input  logic             cfg1_sen_n,
  input  logic             cfg0_sdat,
  input  logic [OFS_W-1:0] pload_word,
  input  logic             pload_strobe,
  output logic [OFS_W-1:0] ae_ofs_1,
  output logic [OFS_W-1:0] af_ofs_1,
  output logic [OFS_W-1:0] ae_ofs_2,
  output logic [OFS_W-1:0] af_ofs_2,
  output logic             prog_done
);

  localparam int CHAIN_L = 4 * OFS_W;
  localparam int CNT_W   = $clog2(CHAIN_L + 1);

  // decoded view of the pins, meaningful while reset is held
  load_mode_e       dec_mode;
  logic [1:0]       dec_code;
  logic [OFS_W-1:0] reset_val;

  assign dec_code  = {cfg1_sen_n, cfg0_sdat};
  assign dec_mode  = decode_mode(ser_mode_n, dec_code);
  assign reset_val = (dec_mode == MODE_PRESET) ? OFS_W'(preset_value(dec_code)) : '0;

  load_mode_e       mode_q;
  logic [1:0]       code_q;
  logic             ser_step;
  logic             par_step;
  logic [CNT_W-1:0] step_cnt;
  logic [CHAIN_L-1:0] chain_q;

  ofl_cfg_latch u_cfg (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .dec_mode (dec_mode),
    .dec_code (dec_code),
    .mode_q   (mode_q),
    .code_q   (code_q)
  );

  // named load events, observed by the checker
  assign ser_step = mrst_n && (mode_q == MODE_SERIAL)   && !cfg1_sen_n  && !prog_done;
  assign par_step = mrst_n && (mode_q == MODE_PARALLEL) && pload_strobe && !prog_done;

  ofl_chain #(.OFS_W(OFS_W), .CHAIN_L(CHAIN_L)) u_chain (
    .clk       (clk),
    .load_en   (!mrst_n),
    .load_val  (reset_val),
    .ser_shift (ser_step),
    .ser_bit   (cfg0_sdat),
    .par_shift (par_step),
    .par_word  (pload_word),
    .chain_q   (chain_q)
  );

  ofl_progress #(.CHAIN_L(CHAIN_L), .CNT_W(CNT_W)) u_prog (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .mode_q   (mode_q),
    .step     (ser_step || par_step),
    .step_cnt (step_cnt),
    .done_q   (prog_done)
  );

  assign {ae_ofs_1, af_ofs_1, ae_ofs_2, af_ofs_2} = chain_q;

endmodule

// File: rtl/ofl_checker.sv
module ofl_checker
  import ofl_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int CNT_W = $clog2(4 * OFS_W + 1)
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             cfg0_sdat,
  input logic [OFS_W-1:0] pload_word,
  input load_mode_e       mode_q,
  input logic [1:0]       code_q,
  input logic             ser_step,
  input logic             par_step,
  input logic [CNT_W-1:0] step_cnt,
  input logic             cfg1_sen_n,
  input logic [OFS_W-1:0] ae_ofs_1,
  input logic [OFS_W-1:0] af_ofs_1,
  input logic [OFS_W-1:0] ae_ofs_2,
  input logic [OFS_W-1:0] af_ofs_2,
  input logic             prog_done
);

  localparam int CHAIN_L = 4 * OFS_W;
  logic [CHAIN_L-1:0] all_ofs;
  assign all_ofs = {ae_ofs_1, af_ofs_1, ae_ofs_2, af_ofs_2};

  // R1: one edge after an edge with reset low, done must be low
  logic rst_seen_q = 1'b0;
  always @(posedge clk) begin
    if (rst_seen_q) p_reset_clear_r1: assert (!prog_done);
    rst_seen_q <= !mrst_n;
  end

  p_preset_value_r3: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode_q == MODE_PRESET && prog_done) |->
      (ae_ofs_1 == OFS_W'(preset_value(code_q)) && af_ofs_2 == OFS_W'(preset_value(code_q))));

  p_serial_lsb_r4: assert property (@(posedge clk) disable iff (!mrst_n)
    ser_step |=> af_ofs_2[0] == $past(cfg0_sdat));

  p_enable_high_r5: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode_q == MODE_SERIAL && cfg1_sen_n) |=> $stable(all_ofs));

  p_done_count_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    ($rose(prog_done) && mode_q == MODE_SERIAL) |-> step_cnt == CNT_W'(CHAIN_L));

  // R6 and R7: once complete, nothing moves until reset
  p_frozen_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    prog_done |=> (prog_done && $stable(all_ofs)));

  p_parallel_word_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    par_step |=> af_ofs_2 == $past(pload_word));

  p_one_method_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    !(ser_step && par_step));

endmodule

bind flag_offset_loader ofl_checker #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .mrst_n     (mrst_n),
  .cfg0_sdat  (cfg0_sdat),
  .pload_word (pload_word),
  .mode_q     (mode_q),
  .code_q     (code_q),
  .ser_step   (ser_step),
  .par_step   (par_step),
  .step_cnt   (step_cnt),
  .cfg1_sen_n (cfg1_sen_n),
  .ae_ofs_1   (ae_ofs_1),
  .af_ofs_1   (af_ofs_1),
  .ae_ofs_2   (ae_ofs_2),
  .af_ofs_2   (af_ofs_2),
  .prog_done  (prog_done)
);

// File: tb/tb_flag_offset_loader.sv
module tb_flag_offset_loader;

  localparam int W = 10;
  localparam int L = 4 * W;

  logic         clk = 1'b0;
  logic         mrst_n = 1'b0;
  logic         ser_mode_n = 1'b1;
  logic         cfg1_sen_n = 1'b1;
  logic         cfg0_sdat = 1'b1;
  logic [W-1:0] pload_word = '0;
  logic         pload_strobe = 1'b0;
  logic [W-1:0] ae_ofs_1, af_ofs_1, ae_ofs_2, af_ofs_2;
  logic         prog_done;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  flag_offset_loader #(.OFS_W(W)) dut (
    .clk(clk), .mrst_n(mrst_n), .ser_mode_n(ser_mode_n),
    .cfg1_sen_n(cfg1_sen_n), .cfg0_sdat(cfg0_sdat),
    .pload_word(pload_word), .pload_strobe(pload_strobe),
    .ae_ofs_1(ae_ofs_1), .af_ofs_1(af_ofs_1),
    .ae_ofs_2(ae_ofs_2), .af_ofs_2(af_ofs_2),
    .prog_done(prog_done)
  );

  typedef struct packed {
    logic         smn;
    logic [1:0]   code;
    logic [W-1:0] exp_ofs;
    logic         exp_done;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 2'b00, 10'd64, 1'b1},
    '{1'b1, 2'b01, 10'd16, 1'b1},
    '{1'b1, 2'b10, 10'd8,  1'b1},
    '{1'b1, 2'b11, 10'd0,  1'b0},
    '{1'b0, 2'b00, 10'd0,  1'b0}
  };

  function automatic logic [L-1:0] ofs_all();
    return {ae_ofs_1, af_ofs_1, ae_ofs_2, af_ofs_2};
  endfunction

  task automatic check(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // called at a negedge; leaves at the negedge after release
  task automatic do_reset(input logic smn, input logic [1:0] code);
    mrst_n = 1'b0; ser_mode_n = smn; {cfg1_sen_n, cfg0_sdat} = code;
    pload_strobe = 1'b0;
    repeat (3) @(negedge clk);
    mrst_n = 1'b1; cfg1_sen_n = 1'b1; cfg0_sdat = 1'b0;
  endtask

  task automatic ser_bit(input logic b);
    cfg1_sen_n = 1'b0; cfg0_sdat = b;
    @(negedge clk);
    cfg1_sen_n = 1'b1;
  endtask

  task automatic ser_gap(input logic junk);
    cfg1_sen_n = 1'b1; cfg0_sdat = junk;
    @(negedge clk);
  endtask

  task automatic par_word(input logic [W-1:0] w);
    pload_strobe = 1'b1; pload_word = w;
    @(negedge clk);
    pload_strobe = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [L-1:0] pat;
    logic [L-1:0] held;
    pat = {10'h2A5, 10'h13C, 10'h0F1, 10'h301};
    @(negedge clk);

    // R1: reset state with preset 64 still being held
    mrst_n = 1'b0; ser_mode_n = 1'b1; {cfg1_sen_n, cfg0_sdat} = 2'b00;
    repeat (2) @(negedge clk);
    check("R1 done low in reset", {39'd0, prog_done}, '0);
    check("R1 preset during reset", ofs_all(), {4{10'd64}});

    // R2/R3: method capture table
    foreach (VECS[i]) begin
      do_reset(VECS[i].smn, VECS[i].code);
      @(negedge clk);
      check($sformatf("R2 R3 vec%0d offsets", i), ofs_all(), {4{VECS[i].exp_ofs}});
      check($sformatf("R2 R3 vec%0d done", i), {39'd0, prog_done}, {39'd0, VECS[i].exp_done});
    end

    // R3: pins and strobe ignored after a preset
    do_reset(1'b1, 2'b10);
    ser_bit(1'b1); ser_bit(1'b1); par_word(10'h3FF);
    check("R3 preset ignores inputs", ofs_all(), {4{10'd8}});

    // R4/R5/R6: serial load with idle gaps carrying junk data
    do_reset(1'b0, 2'b00);
    for (int k = L - 1; k >= 0; k--) begin
      ser_bit(pat[k]);
      if (k % 3 == 0) ser_gap(~pat[k]);
      if (k == 1) check("R6 not done one bit early", {39'd0, prog_done}, '0);
      if (k == L - 1) check("R4 first bit in LSB", ofs_all(), {39'd0, pat[L-1]});
    end
    check("R4 R5 serial chain order", ofs_all(), pat);
    check("R6 done after full chain", {39'd0, prog_done}, {39'd0, 1'b1});
    ser_bit(1'b0); ser_bit(1'b1);
    check("R6 extra bits ignored", ofs_all(), pat);

    // R5: enable high alone takes nothing
    do_reset(1'b0, 2'b00);
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
    held = ofs_all();
    check("R4 three bits", held, {37'd0, 3'b101});
    ser_gap(1'b1); ser_gap(1'b0); ser_gap(1'b1);
    check("R5 enable high no shift", ofs_all(), held);

    // R8: strobe ignored in serial mode
    par_word(10'h3FF); par_word(10'h155);
    check("R8 strobe ignored in serial", ofs_all(), held);

    // R9: reset wins over a bit on the same edge
    mrst_n = 1'b0; cfg1_sen_n = 1'b0; cfg0_sdat = 1'b1;
    @(negedge clk);
    check("R9 reset beats shift", ofs_all(), '0);
    check("R9 done low", {39'd0, prog_done}, '0);
    do_reset(1'b1, 2'b01);
    @(negedge clk);
    check("R9 reprogram preset 16", ofs_all(), {4{10'd16}});

    // R7/R8: parallel load with serial enable flapping between words
    do_reset(1'b1, 2'b11);
    par_word(10'h111); ser_bit(1'b1);
    par_word(10'h222); ser_bit(1'b0);
    par_word(10'h333);
    check("R7 not done after three", {39'd0, prog_done}, '0);
    check("R8 serial ignored in parallel", ofs_all(), {10'd0, 10'h111, 10'h222, 10'h333});
    par_word(10'h044);
    check("R7 parallel order", ofs_all(), {10'h111, 10'h222, 10'h333, 10'h044});
    check("R7 done after four", {39'd0, prog_done}, {39'd0, 1'b1});
    par_word(10'h3FF);
    check("R7 extra strobe ignored", ofs_all(), {10'h111, 10'h222, 10'h333, 10'h044});

    finish_run();
  end

endmodule